// File: doc/BRIEF.md
# Qualified Performance Event Detector Pair

This block is a pair of configurable event detectors for a processor core that runs two hardware threads. A functional unit presents, every cycle, one 16-bit sub-condition vector for each of its event sources and each thread. It also reports whether each thread is currently in OS (privileged) or user mode. Each detector has its own control register. That register names one event source and a mask of the sub-conditions of interest. It also holds four enable bits, one for each combination of thread and privilege mode. The detector counts the masked sub-conditions that fired in every thread slot whose current thread-and-mode combination is enabled. The sum goes out as a 4-bit increment toward a shared counter block.

Both detectors see the same registered event stream. One pair can therefore watch a single event for both threads at once, or two events for one thread. A tag-enable bit and a 3-bit tag value are held in each control register and passed straight to outputs. A register write port and a read port let the control registers be loaded and inspected.

Top module: `evd_pair`

## Requirements
- R1: After reset both control registers read back as zero and both increments are zero.
- R2: A write with `cfg_wr_en` high loads `cfg_wr_data` into the detector chosen by `cfg_wr_idx` at the clock edge. The increment uses the new setting from the cycle after the write, and the other detector's register is unchanged.
- R3: Bit 31 of the control register is reserved. It always reads back as zero, and writing a one to it changes nothing.
- R4: Field bits [30:24] select the event source. `ev_in[(t*NUM_EVENTS+e)*16 +: 16]` carries the vector of thread t for source e. A select value of `NUM_EVENTS` or above gives an increment of zero.
- R5: Field bits [23:8] are the sub-condition mask. Only bits set in both the selected vector and the mask are counted, one per set bit.
- R6: Bits [3:0] are the qualification enables: bit 3 is thread 0 in OS mode, bit 2 is thread 0 in user mode, bit 1 is thread 1 in OS mode and bit 0 is thread 1 in user mode. A thread slot contributes only when the bit for that thread's current mode is set (`priv_os_in[t]` is 1 for OS mode). Mixed settings, such as thread 0 user together with thread 1 OS, are allowed.
- R7: The increment is the sum of the contributions of both thread slots, saturated at 15.
- R8: `ev_in` and `priv_os_in` are registered at the block's input. The increment reflects the values presented before the previous clock edge and does not change between edges.
- R9: Bit 4 (tag enable) and bits [7:5] (tag value) of each detector's register appear unchanged on `tag_en_out` and `tag_val_out`.
- R10: The two detectors are independent. Each computes its increment from its own register over the shared event inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_idx | input | 1 | Detector receiving the write |
| cfg_wr_data | input | 32 | Value written |
| cfg_rd_idx | input | 1 | Detector whose register is read |
| cfg_rd_data | output | 32 | Register read-back, bit 31 zero |
| ev_in | input | 2*NUM_EVENTS*16 | Per-thread, per-source sub-condition vectors |
| priv_os_in | input | 2 | Per-thread mode, 1 = OS, 0 = user |
| inc_out | output | 8 | Increments, detector d at bits [4*d +: 4] |
| tag_en_out | output | 2 | Tag enable of each detector |
| tag_val_out | output | 6 | Tag value, detector d at bits [3*d +: 3] |

## Verification
The assertions check the following on every cycle:
- A write lands exactly in the register it addresses, and a register does not move without a write.
- The reserved bit reads zero.
- The increment is zero whenever the select value names no source, the mask is empty or all four qualification bits are clear.

The bench's sweeps are needed for the rest: the exact counts for each combination of source, qualification bits and per-thread privilege, the saturation point, the one-cycle input latency and the timing of a new setting. Only the sweeps show that these come out right for both detectors while the other detector holds a different setting.

// File: rtl/evd_pkg.sv
package evd_pkg;

    localparam int CFG_W       = 32;
    localparam int SEL_W       = 7;
    localparam int MASK_W      = 16;
    localparam int TAG_W       = 3;
    localparam int QUAL_W      = 4;
    localparam int NUM_THREADS = 2;
    localparam int NUM_DET     = 2;
    localparam int INC_W       = 4;
    localparam int INC_MAX     = (1 << INC_W) - 1;
    localparam int HIT_W       = $clog2(MASK_W + 1);
    localparam int SUM_W       = $clog2(NUM_THREADS * MASK_W + 1);

    // Stored control fields, most significant first: select, mask, tag, tag enable, qualifiers.
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [MASK_W-1:0] mask;
        logic [TAG_W-1:0]  tag;
        logic              tag_en;
        logic [QUAL_W-1:0] qual;
    } cfg_t;

    localparam int STORED_W = $bits(cfg_t);

    // Position of the enable bit for thread t in the given mode.
    function automatic logic [1:0] qual_index(input int t, input logic is_os);
        int idx;
        idx = (QUAL_W - 1) - 2 * t - (is_os ? 0 : 1);
        return 2'(idx);
    endfunction

    function automatic logic [HIT_W-1:0] count_ones(input logic [MASK_W-1:0] v);
        logic [HIT_W-1:0] n;
        n = '0;
        for (int i = 0; i < MASK_W; i++) begin
            n = n + HIT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/evd_input_reg.sv
module evd_input_reg
    import evd_pkg::*;
#(
    parameter int NUM_EVENTS = 4,
    localparam int EV_W = NUM_THREADS * NUM_EVENTS * MASK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [EV_W-1:0]        ev_in,
    input  logic [NUM_THREADS-1:0] priv_in,
    output logic [EV_W-1:0]        ev_q,
    output logic [NUM_THREADS-1:0] priv_q
);

    typedef struct packed {
        logic [EV_W-1:0]        ev;
        logic [NUM_THREADS-1:0] priv;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ev   = ev_in;
        st_d.priv = priv_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev_q   = st_q.ev;
    assign priv_q = st_q.priv;

endmodule

// File: rtl/evd_cfg_reg.sv
module evd_cfg_reg
    import evd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg_o
);

    typedef struct packed {
        cfg_t cfg;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // The reserved top bit is simply not stored.
            st_d.cfg = cfg_t'(wr_data[STORED_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

    // R2: a write lands in the register at the next edge.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.cfg == cfg_t'($past(wr_data[STORED_W-1:0]))));

    // R2: without a write the register holds its value.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.cfg));

endmodule

// File: rtl/evd_qualify.sv
module evd_qualify
    import evd_pkg::*;
#(
    parameter int NUM_EVENTS = 4,
    localparam int EV_W = NUM_THREADS * NUM_EVENTS * MASK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SEL_W-1:0]       sel,
    input  logic [MASK_W-1:0]      mask,
    input  logic [QUAL_W-1:0]      qual,
    input  logic [EV_W-1:0]        ev,
    input  logic [NUM_THREADS-1:0] priv,
    output logic [INC_W-1:0]       inc
);

    logic [NUM_THREADS-1:0][MASK_W-1:0] slot_vec;
    logic [NUM_THREADS-1:0][HIT_W-1:0]  slot_hits;
    logic [NUM_THREADS-1:0]             slot_ok;
    logic [SUM_W-1:0]                   total;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        always_comb begin
            slot_vec[t] = '0;
            for (int e = 0; e < NUM_EVENTS; e++) begin
                if (sel == SEL_W'(e)) begin
                    slot_vec[t] = ev[(t * NUM_EVENTS + e) * MASK_W +: MASK_W];
                end
            end
            slot_hits[t] = count_ones(slot_vec[t] & mask);
            slot_ok[t]   = qual[qual_index(t, priv[t])];
        end
    end

    always_comb begin
        total = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (slot_ok[t]) begin
                total = total + SUM_W'(slot_hits[t]);
            end
        end
        inc = (total > SUM_W'(INC_MAX)) ? INC_W'(INC_MAX) : total[INC_W-1:0];
    end

    // R4: a select value naming no source yields nothing.
    p_unknown_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= SEL_W'(NUM_EVENTS)) |-> (inc == '0));

    // R5: an empty mask yields nothing.
    p_empty_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (inc == '0));

    // R6: no enabled thread/mode combination yields nothing.
    p_no_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (qual == '0) |-> (inc == '0));

endmodule

// File: rtl/evd_pair.sv
module evd_pair
    import evd_pkg::*;
#(
    parameter int NUM_EVENTS = 4,
    localparam int EV_W = NUM_THREADS * NUM_EVENTS * MASK_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr_en,
    input  logic                       cfg_wr_idx,
    input  logic [CFG_W-1:0]           cfg_wr_data,
    input  logic                       cfg_rd_idx,
    output logic [CFG_W-1:0]           cfg_rd_data,
    input  logic [EV_W-1:0]            ev_in,
    input  logic [NUM_THREADS-1:0]     priv_os_in,
    output logic [NUM_DET*INC_W-1:0]   inc_out,
    output logic [NUM_DET-1:0]         tag_en_out,
    output logic [NUM_DET*TAG_W-1:0]   tag_val_out
);

    logic [EV_W-1:0]        ev_r;
    logic [NUM_THREADS-1:0] priv_r;
    cfg_t                   cfg_arr [NUM_DET];

    evd_input_reg #(.NUM_EVENTS(NUM_EVENTS)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_in   (ev_in),
        .priv_in (priv_os_in),
        .ev_q    (ev_r),
        .priv_q  (priv_r)
    );

    for (genvar d = 0; d < NUM_DET; d++) begin : g_det
        logic wr_hit;
        assign wr_hit = cfg_wr_en && (cfg_wr_idx == 1'(d));

        evd_cfg_reg u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_data (cfg_wr_data),
            .cfg_o   (cfg_arr[d])
        );

        evd_qualify #(.NUM_EVENTS(NUM_EVENTS)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (cfg_arr[d].sel),
            .mask  (cfg_arr[d].mask),
            .qual  (cfg_arr[d].qual),
            .ev    (ev_r),
            .priv  (priv_r),
            .inc   (inc_out[d*INC_W +: INC_W])
        );

        assign tag_en_out[d]               = cfg_arr[d].tag_en;
        assign tag_val_out[d*TAG_W +: TAG_W] = cfg_arr[d].tag;
    end

    always_comb begin
        cfg_rd_data = '0;
        cfg_rd_data[STORED_W-1:0] = cfg_arr[cfg_rd_idx];
    end

    // R3: the reserved bit always reads as zero.
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[CFG_W-1] == 1'b0);

endmodule

// File: tb/evd_pair_tb.sv
module evd_pair_tb;

    localparam int NE   = 4;
    localparam int EVW  = 2 * NE * 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr_en = 1'b0;
    logic            cfg_wr_idx = 1'b0;
    logic [31:0]     cfg_wr_data = '0;
    logic            cfg_rd_idx = 1'b0;
    logic [31:0]     cfg_rd_data;
    logic [EVW-1:0]  ev_in = '0;
    logic [1:0]      priv_os_in = '0;
    logic [7:0]      inc_out;
    logic [1:0]      tag_en_out;
    logic [5:0]      tag_val_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] model [2];

    always #5 clk = ~clk;

    evd_pair #(.NUM_EVENTS(NE)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_idx  (cfg_wr_idx),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_idx  (cfg_rd_idx),
        .cfg_rd_data (cfg_rd_data),
        .ev_in       (ev_in),
        .priv_os_in  (priv_os_in),
        .inc_out     (inc_out),
        .tag_en_out  (tag_en_out),
        .tag_val_out (tag_val_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] expect_inc(input logic [31:0] c, input logic [EVW-1:0] ev,
                                              input logic [1:0] pv);
        int sum = 0;
        int sel = int'(c[30:24]);
        for (int t = 0; t < 2; t++) begin
            int bitpos = pv[t] ? (3 - 2 * t) : (2 - 2 * t);
            if (c[bitpos] && sel < NE) begin
                sum += $countones(ev[(t * NE + sel) * 16 +: 16] & c[23:8]);
            end
        end
        return (sum > 15) ? 4'hF : 4'(sum);
    endfunction

    function automatic logic [EVW-1:0] pattern(input int seed);
        logic [EVW-1:0] v;
        for (int s = 0; s < 2 * NE; s++) begin
            v[s * 16 +: 16] = 16'(seed * 40503 + s * 4919 + (s + 1) * (seed + 3) * 77);
        end
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drives a write at the current negedge; it lands at the next edge.
    task automatic write_cfg(input int idx, input logic [31:0] data);
        cfg_wr_en   = 1'b1;
        cfg_wr_idx  = 1'(idx);
        cfg_wr_data = data;
        model[idx]  = data & 32'h7FFF_FFFF;
        step();
        cfg_wr_en   = 1'b0;
    endtask

    task automatic check_both(input string req);
        check(req, {28'd0, inc_out[3:0]}, {28'd0, expect_inc(model[0], ev_in, priv_os_in)});
        check(req, {28'd0, inc_out[7:4]}, {28'd0, expect_inc(model[1], ev_in, priv_os_in)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model[0] = '0;
        model[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cfg_rd_idx = 1'b0; #1;
        check("R1 rd0", cfg_rd_data, 32'h0);
        cfg_rd_idx = 1'b1; #1;
        check("R1 rd1", cfg_rd_data, 32'h0);
        check("R1 inc", {24'd0, inc_out}, 32'h0);

        // R3 and R2: reserved bit dropped, value stored, other detector untouched (R10)
        write_cfg(0, 32'hFFFF_FFFF);
        cfg_rd_idx = 1'b0; #1;
        check("R3 reserved", cfg_rd_data, 32'h7FFF_FFFF);
        cfg_rd_idx = 1'b1; #1;
        check("R10 other untouched", cfg_rd_data, 32'h0);
        write_cfg(0, 32'h8000_0000);
        cfg_rd_idx = 1'b0; #1;
        check("R3 write of reserved only", cfg_rd_data, 32'h0);

        // R9: tag pass-through
        write_cfg(1, {1'b0, 7'd0, 16'd0, 3'b101, 1'b1, 4'd0});
        check("R9 tag_en", {30'd0, tag_en_out}, 32'h2);
        check("R9 tag_val", {26'd0, tag_val_out}, {26'd0, 3'b101, 3'b000});
        write_cfg(1, 32'h0);

        // R8: input latency, increment stable between edges
        write_cfg(0, {1'b0, 7'd1, 16'hFFFF, 4'd0, 4'hF});
        ev_in = '0;
        ev_in[(0 * NE + 1) * 16 +: 16] = 16'h0007;
        priv_os_in = 2'b00;
        #1;
        check("R8 before edge", {28'd0, inc_out[3:0]}, 32'h0);
        step();
        check("R8 after edge", {28'd0, inc_out[3:0]}, 32'h3);

        // R2: a new setting applies from the cycle after the write
        cfg_wr_en = 1'b1; cfg_wr_idx = 1'b0;
        cfg_wr_data = {1'b0, 7'd1, 16'h0001, 4'd0, 4'hF};
        #1;
        check("R2 old setting still used", {28'd0, inc_out[3:0]}, 32'h3);
        step();
        cfg_wr_en = 1'b0;
        model[0] = {1'b0, 7'd1, 16'h0001, 4'd0, 4'hF};
        check("R2 new setting used", {28'd0, inc_out[3:0]}, 32'h1);

        // R6: mixed qualification, thread 0 user plus thread 1 OS
        ev_in = '0;
        ev_in[(0 * NE + 2) * 16 +: 16] = 16'h000F;
        ev_in[(1 * NE + 2) * 16 +: 16] = 16'h0003;
        write_cfg(0, {1'b0, 7'd2, 16'hFFFF, 4'd0, 4'b0110});
        priv_os_in = 2'b10;
        step();
        check("R6 mixed both", {28'd0, inc_out[3:0]}, 32'd6);
        priv_os_in = 2'b01;
        step();
        check("R6 mixed neither", {28'd0, inc_out[3:0]}, 32'd0);

        // R7: saturation boundary
        ev_in = '1;
        priv_os_in = 2'b11;
        write_cfg(0, {1'b0, 7'd0, 16'hFFFF, 4'd0, 4'b1010});
        check("R7 sum 32 saturates", {28'd0, inc_out[3:0]}, 32'd15);
        write_cfg(0, {1'b0, 7'd0, 16'h00FF, 4'd0, 4'b1010});
        check("R7 sum 16 saturates", {28'd0, inc_out[3:0]}, 32'd15);
        write_cfg(0, {1'b0, 7'd0, 16'h007F, 4'd0, 4'b1010});
        check("R7 sum 14 exact", {28'd0, inc_out[3:0]}, 32'd14);
        write_cfg(0, {1'b0, 7'd0, 16'hFFFF, 4'd0, 4'b1000});
        check("R7 single slot 16 saturates", {28'd0, inc_out[3:0]}, 32'd15);

        // R4: out-of-range select
        write_cfg(0, {1'b0, 7'd4, 16'hFFFF, 4'd0, 4'hF});
        check("R4 select 4 zero", {28'd0, inc_out[3:0]}, 32'd0);
        write_cfg(0, {1'b0, 7'd127, 16'hFFFF, 4'd0, 4'hF});
        check("R4 select 127 zero", {28'd0, inc_out[3:0]}, 32'd0);

        // R4 R5 R6 R7 R10: sweep of select, qualifiers and modes for both detectors
        for (int d = 0; d < 2; d++) begin
            for (int sel = 0; sel < 6; sel++) begin
                for (int q = 0; q < 16; q++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [15:0] m;
                        m = (k == 0) ? 16'hFFFF : 16'(16'hA5C3 ^ (sel * 4369));
                        write_cfg(1 - d, {1'b0, 7'((sel + 1) % 6), 16'h0F0F, 4'd0, 4'(15 - q)});
                        write_cfg(d, {1'b0, 7'(sel), m, 4'd0, 4'(q)});
                        for (int p = 0; p < 4; p++) begin
                            ev_in = pattern(sel * 64 + q * 4 + p + k * 1000);
                            priv_os_in = 2'(p);
                            step();
                            check_both("R5 R6 R10 sweep");
                        end
                    end
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule